// File: doc/BRIEF.md
# Interruption Entry State Sequencer

This block moves a processor's architectural state into its interruption registers when a trap or an external interrupt is taken. A single-cycle request strobe carries a 6-bit vector number. On the accepting edge the sequencer snapshots the current status word, the instruction address queues and the space queues. In the same edge it loads a fresh status word, computes the handler entry address, zeroes the space queues and, when state collection is enabled, copies seven general registers into shadow slots.

For a subset of trap classes the faulting instruction word must also be recorded. The sequencer then requests the word at the front offset, aligned to four bytes, through a simple fetch handshake. A failed fetch records zero. A one-cycle done pulse closes every entry sequence, and requests that arrive while the block is busy are dropped.

Top module: `trap_entry_seq`

## Requirements
- R1: A request (`req_valid` high while `busy` is low) is accepted on the clock edge. `busy` is high from the next cycle until the end of the one-cycle `done` pulse. Requests seen while `busy` is high, including during the `done` cycle, change no output.
- R2: `saved_status` takes the value of `cur_status` sampled on the accepting edge, and holds it until the next accepted request.
- R3: `status_out` is loaded on acceptance with all bits zero except two. Bit 4 (machine check) is set when the vector is 1. Bit 5 (wide mode) equals parameter `WIDE`, which is 0 by default.
- R4: On acceptance `isq_front` and `isq_back` take bits [63:32] of `front_space` and `back_space`. `ioq_front` and `ioq_back` take `front_off` and `back_off`.
- R5: Bit 3 of the sampled status word (the collection bit) gates both the shadow copy and the instruction capture. When it is clear, `shadow_regs` and `iir` keep their values and `fetch_req` stays low.
- R6: When the collection bit is set and the vector is one of 12 to 22 or 26 to 28, the block raises `fetch_req` with `fetch_addr` equal to `front_off` with bits [1:0] cleared. On the edge where `fetch_ack` is high, `iir` takes `fetch_data`, or zero if `fetch_err` is high.
- R7: Every other vector, including 8 to 11 (illegal, break and the two privilege traps), leaves `iir` unchanged and raises no fetch.
- R8: When the collection bit is set, shadow slots 0 to 6 (slot k at `shadow_regs[32k +: 32]`) receive general registers 1, 8, 9, 16, 17, 24 and 25, in that order. General register n sits at `gpr_file[32n +: 32]`.
- R9: On acceptance `new_front_off` becomes `vec_base + 32*vector`, modulo 2^32. `new_back_off` becomes that value plus 4, and `new_front_space` and `new_back_space` become zero.
- R10: `done` is high in the cycle after the accepting edge when no fetch is needed. When a fetch is needed, it is high in the cycle after the edge that samples `fetch_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Trap request strobe |
| req_vector | input | 6 | Vector number of the request |
| cur_status | input | 32 | Current status word |
| front_off | input | 32 | Front instruction offset |
| back_off | input | 32 | Back instruction offset |
| front_space | input | 64 | Front space-queue entry |
| back_space | input | 64 | Back space-queue entry |
| vec_base | input | 32 | Vector table base |
| gpr_file | input | 1024 | General registers, register n at [32n +: 32] |
| fetch_ack | input | 1 | Instruction fetch completed |
| fetch_err | input | 1 | Instruction fetch failed |
| fetch_data | input | 32 | Fetched instruction word |
| fetch_req | output | 1 | Instruction fetch request |
| fetch_addr | output | 32 | Word-aligned fetch address |
| busy | output | 1 | Entry sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| status_out | output | 32 | New status word |
| saved_status | output | 32 | Saved status word |
| isq_front | output | 32 | Interruption space register, front |
| isq_back | output | 32 | Interruption space register, back |
| ioq_front | output | 32 | Interruption offset register, front |
| ioq_back | output | 32 | Interruption offset register, back |
| iir | output | 32 | Interruption instruction register |
| shadow_regs | output | 224 | Seven shadow registers |
| new_front_off | output | 32 | Redirected front offset |
| new_back_off | output | 32 | Redirected back offset |
| new_front_space | output | 64 | Redirected front space |
| new_back_space | output | 64 | Redirected back space |

## Verification
Two events can share a cycle: the completion pulse of one entry, and a fresh request strobe held high from the previous trap. The bench provokes this by keeping `req_valid` high, with a different vector and state, across the whole busy period including the `done` cycle. Fetch acknowledgements arrive after varying delays. A behavioural model then expects the stale request to be dropped, with `busy` falling and no register moving. It also expects a request issued in the very next cycle to be accepted normally.

// File: rtl/trap_seq_pkg.sv
// Shared constants, trap-class helpers and state type for the entry sequencer.
// Assumes the bit layout of the status word given by the STAT_* constants.
package trap_seq_pkg;

    localparam int STAT_Q     = 3;   // state-collection enable
    localparam int STAT_M     = 4;   // machine-check mask
    localparam int STAT_W     = 5;   // wide mode
    localparam int VEC_MCHECK = 1;   // high-priority machine check vector
    localparam int NUM_SHADOW = 7;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_FETCH = 2'd1,
        SEQ_DONE  = 2'd2
    } seq_state_t;

    // True for trap classes that record the faulting instruction word.
    function automatic logic captures_insn(input int vec);
        return ((vec >= 12) && (vec <= 22)) || ((vec >= 26) && (vec <= 28));
    endfunction

    // General register copied into shadow slot k.
    function automatic int shadow_src(input int k);
        case (k)
            0:       return 1;
            1:       return 8;
            2:       return 9;
            3:       return 16;
            4:       return 17;
            5:       return 24;
            default: return 25;
        endcase
    endfunction

endpackage

// File: rtl/trap_class_decode.sv
// Classifies a vector number: machine-check flag and instruction-capture flag.
// Purely combinational; assumes vector numbers fit in VEC_W bits.
module trap_class_decode #(
    parameter int VEC_W = 6
) (
    input  logic [VEC_W-1:0] vec,
    output logic             is_mcheck,
    output logic             need_insn
);
    import trap_seq_pkg::*;

    // Decode the class of the requested vector.
    always_comb begin
        is_mcheck = (int'(vec) == VEC_MCHECK);
        need_insn = captures_insn(int'(vec));
    end
endmodule

// File: rtl/trap_vector_calc.sv
// Handler entry address: base plus 32 times the vector, back offset 4 beyond.
// Assumes XLEN >= VEC_W + 5; results wrap modulo 2^XLEN.
module trap_vector_calc #(
    parameter int XLEN  = 32,
    parameter int VEC_W = 6
) (
    input  logic [XLEN-1:0]  base,
    input  logic [VEC_W-1:0] vec,
    output logic [XLEN-1:0]  front,
    output logic [XLEN-1:0]  back
);
    localparam int PAD = XLEN - VEC_W - 5;

    // Scale the vector by the 32-byte slot size and add the base.
    always_comb begin
        front = base + {{PAD{1'b0}}, vec, 5'b00000};
        back  = front + XLEN'(4);
    end
endmodule

// File: rtl/trap_shadow_bank.sv
// Seven shadow registers loaded in one edge from fixed general registers.
// Assumes the register file is presented flat, register n at [XLEN*n +: XLEN].
module trap_shadow_bank #(
    parameter int XLEN = 32,
    parameter int NGPR = 32
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      load,
    input  logic [NGPR*XLEN-1:0]                      gpr_file,
    output logic [trap_seq_pkg::NUM_SHADOW*XLEN-1:0]  shadow_out
);
    import trap_seq_pkg::*;

    logic unused_gpr;
    assign unused_gpr = ^gpr_file;

    for (genvar k = 0; k < NUM_SHADOW; k++) begin : g_slot
        localparam int SRC = shadow_src(k);
        // Capture one source register into its slot on load.
        always_ff @(posedge clk) begin
            if (!rst_n)
                shadow_out[k*XLEN +: XLEN] <= '0;
            else if (load)
                shadow_out[k*XLEN +: XLEN] <= gpr_file[SRC*XLEN +: XLEN];
        end
    end
endmodule

// File: rtl/trap_entry_seq.sv
// Interruption entry sequencer. On an accepted request it saves the status
// word and address queues, loads a fresh status word and the handler address,
// and, with collection enabled, shadows registers and fetches the faulting
// instruction. Assumes SPACE_W is even and fetch_ack is a one-cycle strobe.
module trap_entry_seq #(
    parameter int XLEN    = 32,
    parameter int SPACE_W = 64,
    parameter int VEC_W   = 6,
    parameter int INSN_W  = 32,
    parameter int NGPR    = 32,
    parameter bit WIDE    = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [VEC_W-1:0]         req_vector,
    input  logic [XLEN-1:0]          cur_status,
    input  logic [XLEN-1:0]          front_off,
    input  logic [XLEN-1:0]          back_off,
    input  logic [SPACE_W-1:0]       front_space,
    input  logic [SPACE_W-1:0]       back_space,
    input  logic [XLEN-1:0]          vec_base,
    input  logic [NGPR*XLEN-1:0]     gpr_file,
    input  logic                     fetch_ack,
    input  logic                     fetch_err,
    input  logic [INSN_W-1:0]        fetch_data,
    output logic                     fetch_req,
    output logic [XLEN-1:0]          fetch_addr,
    output logic                     busy,
    output logic                     done,
    output logic [XLEN-1:0]          status_out,
    output logic [XLEN-1:0]          saved_status,
    output logic [SPACE_W/2-1:0]     isq_front,
    output logic [SPACE_W/2-1:0]     isq_back,
    output logic [XLEN-1:0]          ioq_front,
    output logic [XLEN-1:0]          ioq_back,
    output logic [INSN_W-1:0]        iir,
    output logic [7*XLEN-1:0]        shadow_regs,
    output logic [XLEN-1:0]          new_front_off,
    output logic [XLEN-1:0]          new_back_off,
    output logic [SPACE_W-1:0]       new_front_space,
    output logic [SPACE_W-1:0]       new_back_space
);
    import trap_seq_pkg::*;

    localparam int HALF = SPACE_W / 2;

    seq_state_t      state;
    logic            accept;
    logic            collect;
    logic            is_mcheck;
    logic            need_insn;
    logic [XLEN-1:0] fresh_status;
    logic [XLEN-1:0] vec_front;
    logic [XLEN-1:0] vec_back;
    logic            unused_low;

    assign unused_low = ^{front_space[HALF-1:0], back_space[HALF-1:0]};

    trap_class_decode #(.VEC_W(VEC_W)) u_decode (
        .vec       (req_vector),
        .is_mcheck (is_mcheck),
        .need_insn (need_insn)
    );

    trap_vector_calc #(.XLEN(XLEN), .VEC_W(VEC_W)) u_vector (
        .base  (vec_base),
        .vec   (req_vector),
        .front (vec_front),
        .back  (vec_back)
    );

    trap_shadow_bank #(.XLEN(XLEN), .NGPR(NGPR)) u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept && collect),
        .gpr_file   (gpr_file),
        .shadow_out (shadow_regs)
    );

    // Handshake view of the sequencer state.
    always_comb begin
        busy      = (state != SEQ_IDLE);
        done      = (state == SEQ_DONE);
        fetch_req = (state == SEQ_FETCH);
        accept    = req_valid && (state == SEQ_IDLE);
        collect   = cur_status[STAT_Q];
    end

    // Fresh status word: wide-mode and machine-check bits only.
    always_comb begin
        fresh_status         = '0;
        fresh_status[STAT_W] = WIDE;
        fresh_status[STAT_M] = is_mcheck;
    end

    // State sequencing across accept, optional fetch and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
        end else begin
            case (state)
                SEQ_IDLE:  if (accept)
                               state <= (collect && need_insn) ? SEQ_FETCH : SEQ_DONE;
                SEQ_FETCH: if (fetch_ack)
                               state <= SEQ_DONE;
                default:   state <= SEQ_IDLE;
            endcase
        end
    end

    // Save architectural state and load the redirected state on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            saved_status    <= '0;
            status_out      <= '0;
            isq_front       <= '0;
            isq_back        <= '0;
            ioq_front       <= '0;
            ioq_back        <= '0;
            new_front_off   <= '0;
            new_back_off    <= '0;
            new_front_space <= '0;
            new_back_space  <= '0;
            fetch_addr      <= '0;
        end else if (accept) begin
            saved_status    <= cur_status;
            status_out      <= fresh_status;
            isq_front       <= front_space[SPACE_W-1:HALF];
            isq_back        <= back_space[SPACE_W-1:HALF];
            ioq_front       <= front_off;
            ioq_back        <= back_off;
            new_front_off   <= vec_front;
            new_back_off    <= vec_back;
            new_front_space <= '0;
            new_back_space  <= '0;
            fetch_addr      <= {front_off[XLEN-1:2], 2'b00};
        end
    end

    // Record the fetched instruction, or zero on a failed fetch.
    always_ff @(posedge clk) begin
        if (!rst_n)
            iir <= '0;
        else if (state == SEQ_FETCH && fetch_ack)
            iir <= fetch_err ? '0 : fetch_data;
    end
endmodule

// File: rtl/trap_entry_seq_chk.sv
// Property checker for the entry sequencer, bound to every instance.
// Assumes the status bit layout of trap_seq_pkg.
module trap_entry_seq_chk #(
    parameter int XLEN    = 32,
    parameter int SPACE_W = 64,
    parameter int INSN_W  = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               busy,
    input logic               done,
    input logic               fetch_req,
    input logic               fetch_ack,
    input logic [XLEN-1:0]    fetch_addr,
    input logic [XLEN-1:0]    status_out,
    input logic [XLEN-1:0]    saved_status,
    input logic [INSN_W-1:0]  iir,
    input logic [XLEN-1:0]    new_front_off,
    input logic [XLEN-1:0]    new_back_off,
    input logic [SPACE_W-1:0] new_front_space,
    input logic [SPACE_W-1:0] new_back_space
);
    import trap_seq_pkg::*;

    logic [XLEN-1:0] status_allowed;
    always_comb begin
        status_allowed         = '0;
        status_allowed[STAT_M] = 1'b1;
        status_allowed[STAT_W] = 1'b1;
    end

    assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_accept_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);
    assert_saved_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(saved_status));
    assert_status_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((status_out & ~status_allowed) == '0));
    assert_fetch_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> saved_status[STAT_Q]);
    assert_fetch_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> (fetch_addr[1:0] == 2'b00));
    assert_iir_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(fetch_req && fetch_ack) |=> $stable(iir));
    assert_back_offset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (new_back_off == new_front_off + XLEN'(4)));
    assert_space_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (new_front_space == '0 && new_back_space == '0));
    assert_ack_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && fetch_ack) |=> done);
endmodule

bind trap_entry_seq trap_entry_seq_chk #(
    .XLEN(XLEN), .SPACE_W(SPACE_W), .INSN_W(INSN_W)
) u_chk (.*);

// File: tb/test_trap_entry_seq.sv
// Bench for the entry sequencer: behavioural reference model compared at
// every falling edge, directed corner cases plus randomised traps.
module test_trap_entry_seq;
    localparam int XLEN = 32;
    localparam int SW   = 64;
    localparam int VW   = 6;
    localparam int IW   = 32;
    localparam int NG   = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [VW-1:0]     req_vector = '0;
    logic [XLEN-1:0]   cur_status = '0;
    logic [XLEN-1:0]   front_off = '0;
    logic [XLEN-1:0]   back_off = '0;
    logic [SW-1:0]     front_space = '0;
    logic [SW-1:0]     back_space = '0;
    logic [XLEN-1:0]   vec_base = '0;
    logic [NG*XLEN-1:0] gpr_file = '0;
    logic              fetch_ack = 1'b0;
    logic              fetch_err = 1'b0;
    logic [IW-1:0]     fetch_data = '0;
    logic              fetch_req, busy, done;
    logic [XLEN-1:0]   fetch_addr, status_out, saved_status;
    logic [SW/2-1:0]   isq_front, isq_back;
    logic [XLEN-1:0]   ioq_front, ioq_back;
    logic [IW-1:0]     iir;
    logic [7*XLEN-1:0] shadow_regs;
    logic [XLEN-1:0]   new_front_off, new_back_off;
    logic [SW-1:0]     new_front_space, new_back_space;

    always #2 clk = ~clk;   // 250 MHz

    trap_entry_seq i_trap_entry_seq (.*);

    int checks = 0;
    int fails  = 0;
    bit compare_on = 1'b0;

    // Responder settings chosen by the stimulus.
    int cfg_delay = 0;
    bit cfg_err   = 1'b0;

    // ---------------- reference model ----------------
    int              m_mode = 0;          // 0 idle, 1 fetching, 2 finishing
    logic [XLEN-1:0] m_saved = '0, m_status = '0, m_ioqf = '0, m_ioqb = '0;
    logic [XLEN-1:0] m_faddr = '0, m_nfo = '0, m_nbo = '0;
    logic [31:0]     m_isqf = '0, m_isqb = '0;
    logic [IW-1:0]   m_iir = '0;
    logic [XLEN-1:0] m_shadow [7];
    int              src_list [7] = '{1, 8, 9, 16, 17, 24, 25};

    initial for (int k = 0; k < 7; k++) m_shadow[k] = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_saved = '0; m_status = '0; m_ioqf = '0; m_ioqb = '0;
            m_faddr = '0; m_nfo = '0; m_nbo = '0; m_isqf = '0; m_isqb = '0;
            m_iir = '0;
            for (int k = 0; k < 7; k++) m_shadow[k] = '0;
        end else if (m_mode == 0) begin
            if (req_valid) begin
                int v;
                bit q;
                bit cap;
                v = int'(req_vector);
                q = cur_status[3];
                cap = (v inside {[12:22], [26:28]});
                m_saved  = cur_status;
                m_status = '0;
                if (v == 1) m_status[4] = 1'b1;
                m_isqf = front_space[63:32];
                m_isqb = back_space[63:32];
                m_ioqf = front_off;
                m_ioqb = back_off;
                m_nfo  = vec_base + XLEN'(32 * v);
                m_nbo  = m_nfo + 4;
                m_faddr = front_off & ~32'h3;
                if (q)
                    for (int k = 0; k < 7; k++)
                        m_shadow[k] = gpr_file[src_list[k]*XLEN +: XLEN];
                m_mode = (q && cap) ? 1 : 2;
            end
        end else if (m_mode == 1) begin
            if (fetch_ack) begin
                m_iir  = fetch_err ? '0 : fetch_data;
                m_mode = 2;
            end
        end else begin
            m_mode = 0;
        end
    end

    task automatic chk(input string tag, input logic [255:0] got, input logic [255:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    // Compare every output with the model away from the active edge.
    always @(negedge clk) begin
        if (compare_on) begin
            logic [7*XLEN-1:0] sflat;
            for (int k = 0; k < 7; k++) sflat[k*XLEN +: XLEN] = m_shadow[k];
            chk("R1 busy", 256'(busy), 256'(m_mode != 0));
            chk("R10 done", 256'(done), 256'(m_mode == 2));
            chk("R6 fetch_req", 256'(fetch_req), 256'(m_mode == 1));
            if (m_mode == 1) chk("R6 fetch_addr", 256'(fetch_addr), 256'(m_faddr));
            chk("R2 saved_status", 256'(saved_status), 256'(m_saved));
            chk("R3 status_out", 256'(status_out), 256'(m_status));
            chk("R4 isq", 256'({isq_front, isq_back}), 256'({m_isqf, m_isqb}));
            chk("R4 ioq", 256'({ioq_front, ioq_back}), 256'({m_ioqf, m_ioqb}));
            chk("R7 iir", 256'(iir), 256'(m_iir));
            chk("R8 shadow_regs", 256'(shadow_regs), 256'(sflat));
            chk("R9 new offsets", 256'({new_front_off, new_back_off}), 256'({m_nfo, m_nbo}));
            chk("R9 new spaces", 256'({new_front_space, new_back_space}), 256'(0));
        end
    end

    // Fetch responder: acknowledge after cfg_delay cycles of fetch_req.
    initial begin
        int wait_left;
        wait_left = 0;
        forever begin
            @(negedge clk);
            if (fetch_ack) begin
                fetch_ack = 1'b0;
            end else if (fetch_req) begin
                if (wait_left >= cfg_delay) begin
                    fetch_ack  = 1'b1;
                    fetch_err  = cfg_err;
                    fetch_data = $urandom;
                    wait_left  = 0;
                end else begin
                    wait_left++;
                end
            end
        end
    end

    task automatic scramble();
        for (int k = 0; k < NG; k++) gpr_file[k*XLEN +: XLEN] = $urandom;
        front_off   = $urandom;
        back_off    = $urandom;
        front_space = {$urandom, $urandom};
        back_space  = {$urandom, $urandom};
        vec_base    = $urandom;
    endtask

    // Issue one trap; optionally hold the strobe with altered inputs until after done.
    task automatic run_trap(input int vec, input bit q, input bit hold,
                            input bit err, input int delay);
        @(negedge clk);
        scramble();
        cfg_err    = err;
        cfg_delay  = delay;
        cur_status = $urandom;
        cur_status[3] = q;
        req_vector = VW'(vec);
        req_valid  = 1'b1;
        @(negedge clk);
        if (hold) begin
            scramble();
            cur_status = ~cur_status;
            req_vector = req_vector + 1'b1;
        end else begin
            req_valid = 1'b0;
        end
        while (!done) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        compare_on = 1'b1;          // reset state checked here (R1..R9 at zero)
        @(negedge clk);
        rst_n = 1'b1;
        run_trap(12, 1'b1, 1'b0, 1'b0, 2);   // R6 capture, R8 shadows
        run_trap(12, 1'b1, 1'b0, 1'b1, 0);   // R6 failed fetch writes zero
        run_trap(1,  1'b0, 1'b0, 1'b0, 0);   // R3 machine check, R5 gated off
        run_trap(8,  1'b1, 1'b0, 1'b0, 0);   // R7 illegal keeps iir
        run_trap(11, 1'b1, 1'b0, 1'b0, 0);   // R7 privilege trap keeps iir
        run_trap(28, 1'b1, 1'b1, 1'b0, 3);   // R1 held strobe ignored while busy
        run_trap(22, 1'b0, 1'b1, 1'b0, 0);   // R5 no capture without collection
        vec_base = 32'hFFFF_FFF0;
        run_trap(63, 1'b1, 1'b0, 1'b0, 0);   // R9 largest vector
        run_trap(26, 1'b1, 1'b0, 1'b0, 1);   // R10 fetch path timing
        for (int n = 0; n < 60; n++)
            run_trap(int'($urandom_range(0, 63)), 1'($urandom), 1'($urandom),
                     1'($urandom), int'($urandom_range(0, 3)));
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got hung run expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule